// File: doc/BRIEF.md
# Fifteen-Cent Vending Controller

A synchronous controller for a machine that sells one item priced at fifteen cents. Customers insert five-cent and ten-cent coins, each on its own one-cycle pulse input. The controller keeps the running credit as a small set of states: zero, five, ten, fifteen and twenty cents. The item is released only when the customer presses the vend button while enough credit is held. A separate refund button gives back whatever credit is held, using return outputs for five, ten and fifteen cents.

Every output is a one-cycle pulse taken from a register. Glitches in the decode logic therefore never reach the coin mechanism, and each response shows up on the clock edge after the input that caused it. If a coin and a button press arrive in the same cycle, the button is served first. The coin is held in a one-slot buffer and credited on the next edge. Any state encoding outside the five credit values falls back to zero credit.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no input activity, all four outputs are low and the credit is zero.
- R2: The credit steps as follows: a nickel adds 5 and a dime adds 10. The sequence 0, 5, 10, 15 is built from nickels. A dime at 10 cents moves the credit to 20. The two coin inputs are never asserted in the same cycle; this is an input rule.
- R3: A vend request with exactly 15 cents of credit pulses drop alone and leaves the credit at zero.
- R4: A vend request with 20 cents of credit pulses drop and return-5 together and leaves the credit at zero.
- R5: A vend request with less than 15 cents of credit produces no output and leaves the credit unchanged.
- R6: A refund request returns the held credit through the outputs as follows, then leaves the credit at zero: 5 gives return-5, 10 gives return-10, 15 gives return-15, and 20 gives return-5 and return-15 together.
- R7: A refund or vend request at zero credit produces no output.
- R8: A coin that arrives while the credit is 15 or 20 is given straight back and the credit is unchanged. A nickel gives return-5 and a dime gives return-10.
- R9: When a coin and a command arrive in the same cycle, the command acts on the credit held before the coin. The coin is credited on the following clock edge.
- R10: When refund and vend are requested in the same cycle, only the refund takes effect.
- R11: Each output pulse appears on the clock edge that samples its cause and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nickel_i | input | 1 | Five-cent coin accepted (one-cycle pulse) |
| dime_i | input | 1 | Ten-cent coin accepted (one-cycle pulse) |
| vend_i | input | 1 | Customer asks for the item (one-cycle pulse) |
| refund_i | input | 1 | Customer asks for the credit back (one-cycle pulse) |
| drop_o | output | 1 | Release one item |
| ret5_o | output | 1 | Return five cents |
| ret10_o | output | 1 | Return ten cents |
| ret15_o | output | 1 | Return fifteen cents |

## Verification
Coin crediting and command handling can both fall in one cycle when a coin pulse coincides with a vend or refund pulse. The bench provokes this by driving a dime together with a refund at 10 cents, and a nickel together with a vend at 15 cents. The check requires that the command's outputs reflect only the credit held before the coin. It then requires that the following idle cycle is silent and that a later refund returns exactly the deferred coin's value. Refund and vend in the same cycle are judged the same way: only the refund outputs may appear, and a later vend must find zero credit.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [2:0] {
    CR0  = 3'd0,
    CR5  = 3'd1,
    CR10 = 3'd2,
    CR15 = 3'd3,
    CR20 = 3'd4
  } credit_e;

  typedef enum logic [1:0] {
    COIN_NONE   = 2'd0,
    COIN_NICKEL = 2'd1,
    COIN_DIME   = 2'd2
  } coin_e;

  typedef struct packed {
    logic drop;
    logic ret5;
    logic ret10;
    logic ret15;
  } vend_out_t;

  localparam vend_out_t OUT_IDLE = '{drop: 1'b0, ret5: 1'b0, ret10: 1'b0, ret15: 1'b0};

endpackage

// File: rtl/vend_coin_hold.sv
module vend_coin_hold
  import vend_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  nickel_i,
  input  logic  dime_i,
  input  logic  cmd_i,
  output coin_e coin_o,
  output logic  pend_o
);

  coin_e live_coin;
  coin_e hold_q;
  coin_e hold_d;
  logic  hold_en;

  always_comb begin
    if (dime_i)        live_coin = COIN_DIME;
    else if (nickel_i) live_coin = COIN_NICKEL;
    else               live_coin = COIN_NONE;
  end

  assign pend_o = (hold_q != COIN_NONE);

  // Commands take the cycle: the coin waits in the slot.
  always_comb begin
    if (cmd_i) begin
      coin_o = COIN_NONE;
      hold_d = pend_o ? hold_q : live_coin;
    end else begin
      coin_o = pend_o ? hold_q : live_coin;
      hold_d = pend_o ? live_coin : COIN_NONE;
    end
  end

  assign hold_en = (hold_d != hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= COIN_NONE;
    else if (hold_en) hold_q <= hold_d;
  end

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
  import vend_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  coin_e     coin_i,
  input  logic      vend_i,
  input  logic      refund_i,
  output credit_e   credit_o,
  output vend_out_t out_d
);

  credit_e state_q;
  credit_e state_d;
  logic    state_en;

  assign credit_o = state_q;

  always_comb begin
    state_d = state_q;
    out_d   = OUT_IDLE;
    if (refund_i) begin
      state_d = CR0;
      case (state_q)
        CR0:     ;
        CR5:     out_d.ret5  = 1'b1;
        CR10:    out_d.ret10 = 1'b1;
        CR15:    out_d.ret15 = 1'b1;
        CR20:    begin out_d.ret5 = 1'b1; out_d.ret15 = 1'b1; end
        default: ;
      endcase
    end else if (vend_i) begin
      case (state_q)
        CR15:    begin state_d = CR0; out_d.drop = 1'b1; end
        CR20:    begin state_d = CR0; out_d.drop = 1'b1; out_d.ret5 = 1'b1; end
        CR0, CR5, CR10: ;
        default: state_d = CR0;
      endcase
    end else begin
      case (state_q)
        CR0: begin
          if (coin_i == COIN_NICKEL)    state_d = CR5;
          else if (coin_i == COIN_DIME) state_d = CR10;
        end
        CR5: begin
          if (coin_i == COIN_NICKEL)    state_d = CR10;
          else if (coin_i == COIN_DIME) state_d = CR15;
        end
        CR10: begin
          if (coin_i == COIN_NICKEL)    state_d = CR15;
          else if (coin_i == COIN_DIME) state_d = CR20;
        end
        CR15, CR20: begin
          out_d.ret5  = (coin_i == COIN_NICKEL);
          out_d.ret10 = (coin_i == COIN_DIME);
        end
        default: state_d = CR0;
      endcase
    end
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= CR0;
    else if (state_en) state_q <= state_d;
  end

endmodule

// File: rtl/vend_out_reg.sv
module vend_out_reg
  import vend_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  vend_out_t out_d,
  output vend_out_t out_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= OUT_IDLE;
    else        out_q <= out_d;
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nickel_i,
  input  logic dime_i,
  input  logic vend_i,
  input  logic refund_i,
  output logic drop_o,
  output logic ret5_o,
  output logic ret10_o,
  output logic ret15_o
);

  coin_e     coin;
  logic      pend;
  credit_e   credit;
  vend_out_t out_d;
  vend_out_t out_q;
  logic      cmd;

  assign cmd = vend_i | refund_i;

  vend_coin_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .cmd_i    (cmd),
    .coin_o   (coin),
    .pend_o   (pend)
  );

  vend_credit_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .coin_i   (coin),
    .vend_i   (vend_i),
    .refund_i (refund_i),
    .credit_o (credit),
    .out_d    (out_d)
  );

  vend_out_reg u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .out_d (out_d),
    .out_q (out_q)
  );

  assign drop_o  = out_q.drop;
  assign ret5_o  = out_q.ret5;
  assign ret10_o = out_q.ret10;
  assign ret15_o = out_q.ret15;

  AST_COIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nickel_i && dime_i)); // R2

  AST_DROP_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> $past(credit == CR15 || credit == CR20)); // R3

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> (credit == CR0)); // R4

  AST_LOW_VEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (vend_i && !refund_i && (credit == CR0 || credit == CR5 || credit == CR10))
      |=> ($stable(credit) && !drop_o)); // R5

  AST_ZERO_REFUND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (refund_i && credit == CR0)
      |=> !(drop_o || ret5_o || ret10_o || ret15_o)); // R7

  AST_COIN_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && (nickel_i || dime_i) && !pend) |=> pend); // R9

  AST_REFUND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (refund_i && vend_i) |=> !drop_o); // R10

endmodule

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;

  logic clk;
  logic rst_n;
  logic nickel_i, dime_i, vend_i, refund_i;
  logic drop_o, ret5_o, ret10_o, ret15_o;
  int   n_vec;
  int   n_bad;

  vend_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .vend_i   (vend_i),
    .refund_i (refund_i),
    .drop_o   (drop_o),
    .ret5_o   (ret5_o),
    .ret10_o  (ret10_o),
    .ret15_o  (ret15_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected bits: {drop, ret5, ret10, ret15}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {drop_o, ret5_o, ret10_o, ret15_o};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs got %b expected %b", req, act, exp);
    end
  endtask

  // drive one cycle of inputs at a falling edge, return at the next one
  task automatic cyc(input logic n, input logic d, input logic v, input logic r);
    nickel_i = n; dime_i = d; vend_i = v; refund_i = r;
    @(negedge clk);
    nickel_i = 1'b0; dime_i = 1'b0; vend_i = 1'b0; refund_i = 1'b0;
  endtask

  task automatic t_reset;
    nickel_i = 1'b0; dime_i = 1'b0; vend_i = 1'b0; refund_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);
    chk("R1 after release", 4'b0000);
    cyc(0, 0, 0, 1);
    chk("R1 zero credit after reset", 4'b0000);
  endtask

  task automatic t_nickels;
    cyc(1, 0, 0, 0); chk("R2 nickel 1", 4'b0000);
    cyc(1, 0, 0, 0); chk("R2 nickel 2", 4'b0000);
    cyc(1, 0, 0, 0); chk("R2 nickel 3", 4'b0000);
    cyc(0, 0, 1, 0); chk("R3 vend at 15", 4'b1000);
    cyc(0, 0, 0, 0); chk("R11 drop one cycle", 4'b0000);
    cyc(0, 0, 0, 1); chk("R3 credit zero after vend", 4'b0000);
  endtask

  task automatic t_dimes;
    cyc(0, 1, 0, 0); chk("R2 dime 1", 4'b0000);
    cyc(0, 1, 0, 0); chk("R2 dime to 20", 4'b0000);
    cyc(0, 0, 1, 0); chk("R4 vend at 20", 4'b1100);
    cyc(0, 0, 0, 1); chk("R4 credit zero after vend", 4'b0000);
  endtask

  task automatic t_low_vend;
    cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0); chk("R5 vend at 10 ignored", 4'b0000);
    cyc(0, 0, 0, 1); chk("R5 credit kept", 4'b0010);
  endtask

  task automatic t_refunds;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 1); chk("R6 refund 5", 4'b0100);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 1); chk("R6 refund 10", 4'b0010);
    cyc(1, 0, 0, 0); cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 1); chk("R6 refund 15", 4'b0001);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 1); chk("R6 refund 20", 4'b0101);
    cyc(0, 0, 0, 0); chk("R11 refund pulse one cycle", 4'b0000);
    cyc(0, 0, 0, 1); chk("R6 zero after refund", 4'b0000);
  endtask

  task automatic t_zero;
    cyc(0, 0, 0, 1); chk("R7 refund at zero", 4'b0000);
    cyc(0, 0, 1, 0); chk("R7 vend at zero", 4'b0000);
  endtask

  task automatic t_overflow;
    cyc(0, 1, 0, 0); cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0); chk("R8 nickel at 15 returned", 4'b0100);
    cyc(0, 1, 0, 0); chk("R8 dime at 15 returned", 4'b0010);
    cyc(0, 0, 1, 0); chk("R8 credit still 15", 4'b1000);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0); chk("R8 nickel at 20 returned", 4'b0100);
    cyc(0, 0, 1, 0); chk("R8 credit still 20", 4'b1100);
  endtask

  task automatic t_same_cycle;
    cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 1); chk("R9 refund before dime", 4'b0010);
    cyc(0, 0, 0, 0); chk("R9 deferred dime silent", 4'b0000);
    cyc(0, 0, 0, 1); chk("R9 deferred dime credited", 4'b0010);
    cyc(0, 1, 0, 0); cyc(1, 0, 0, 0);
    cyc(1, 0, 1, 0); chk("R9 vend before nickel", 4'b1000);
    cyc(0, 0, 0, 0); chk("R9 deferred nickel silent", 4'b0000);
    cyc(0, 0, 0, 1); chk("R9 deferred nickel credited", 4'b0100);
  endtask

  task automatic t_priority;
    cyc(0, 1, 0, 0); cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 1); chk("R10 refund wins over vend", 4'b0001);
    cyc(0, 0, 1, 0); chk("R10 no credit left", 4'b0000);
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_nickels();
    t_dimes();
    t_low_vend();
    t_refunds();
    t_zero();
    t_overflow();
    t_same_cycle();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule